// File: doc/BRIEF.md
# PCI Bus Master Write Sequencer

This block is the initiator half of a PCI write engine. A local client hands it a word address, a word count and a mode bit. It then requests the bus, and once it is granted it writes the words to memory with the Memory Write command. It pulls one 32-bit word and its byte enables from the local port for each completed data phase.

Two transfer styles are available, chosen per operation by `cfg_burst`. In single-phase style, every word is its own transaction. All of these transactions are chained under one grant, with FRAME released between them. In burst style, the whole queue goes out as one linear burst with a single address phase. The block drives even parity one clock behind every driven cycle. If no target claims a transaction within a bounded number of clocks, the block abandons the operation with a master abort.

Top module: `pciw_master_write`

## Requirements
- R1: While `rst_n` is low, `req_n`, `frame_n` and `irdy_n` are high, and `busy` and `abort_err` are low.
- R2: In every address phase (FRAME low, IRDY high), `cbe_n` is 4'b0111 and `ad` is the current word address shifted left by two, so `ad[1:0]` = 2'b00.
- R3: In a data phase, `ad` carries `word_data` and `cbe_n` carries the bitwise inverse of `word_be`. `word_take` is high in exactly the clock in which that phase completes, and words are consumed in order.
- R4: IRDY goes low in the clock right after each address phase. A data phase completes only on a clock where both IRDY and TRDY are low, so each clock of a late DEVSEL or TRDY stretches the phase by one clock.
- R5: With `cfg_burst` low, each word is a separate transaction with one data phase. FRAME is high during that data phase. Consecutive transactions are separated by at least one clock with FRAME and IRDY both high, and the address rises by 4 per word.
- R6: With `cfg_burst` low, `req_n` stays low until the address phase of the final word. It is high from that address phase on.
- R7: With `cfg_burst` high, the operation has exactly one address phase. FRAME stays low through every data phase except the final one, and it is high during the final one.
- R8: With `cfg_burst` high, `req_n` goes high in the address phase.
- R9: In the clock after any clock in which FRAME or IRDY is low, `par` equals the XOR of that clock's `ad` and `cbe_n`.
- R10: If DEVSEL is not low in any of the first ABORT_CLKS (default 4) data-phase clocks of a transaction, then on the next clock FRAME and IRDY are high, `busy` is low and `abort_err` is set. The remaining words are dropped. A DEVSEL in the last of those clocks is still accepted.
- R11: `done` pulses for one clock right after the final phase completes, with `busy` low. A `start` with `start_cnt` = 0 is ignored.
- R12: An address phase begins only on the clock after `gnt_n` was sampled low. Between single-phase transactions, a withdrawn grant sends the block back to requesting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation (taken when idle) |
| start_waddr | input | 30 | First word address (byte address bits 31:2) |
| start_cnt | input | CNT_W | Number of words to write |
| cfg_burst | input | 1 | 1 = one linear burst, 0 = single-phase writes |
| word_data | input | 32 | Current word to write |
| word_be | input | 4 | Active-high byte enables of the current word |
| word_take | output | 1 | Current word consumed this clock |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-clock pulse at normal completion |
| abort_err | output | 1 | Last operation ended in master abort |
| req_n | output | 1 | Bus request |
| gnt_n | input | 1 | Bus grant |
| frame_n | output | 1 | FRAME |
| irdy_n | output | 1 | Initiator ready |
| devsel_n | input | 1 | Target claim |
| trdy_n | input | 1 | Target ready |
| ad | output | 32 | Address/data |
| cbe_n | output | 4 | Command / byte enables |
| par | output | 1 | Even parity, one clock late |

## Verification
The sharpest coincidence is between a target claim that arrives in the final clock of the DEVSEL window and the abort decision that would otherwise be taken in that same clock. The bench makes its target claim three data clocks late, where the transfer must complete normally. It then claims four clocks late, where the abort must win: no word is consumed, the error flag rises and the bus is released on the following clock. A second coincidence is the release of REQ in the same clock as the final FRAME assertion. The scoreboard judges this by checking `req_n` at every address phase against the number of words still queued.

// File: rtl/pciw_pkg.sv
package pciw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_ADDR,
      ST_DATA,
      ST_GAP
   } seq_state_t;

   localparam int          BUS_W        = 32;
   localparam int          LANES        = BUS_W / 8;
   localparam int          WADDR_W      = BUS_W - 2;
   localparam logic [3:0]  CMD_MEM_WR   = 4'b0111;
endpackage

// File: rtl/pciw_seq.sv
module pciw_seq
   import pciw_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int ABORT_CLKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] start_cnt,
   input  logic             cfg_burst,
   input  logic             gnt_n,
   input  logic             devsel_n,
   input  logic             trdy_n,
   output logic             load,
   output logic             phase_done,
   output logic             in_addr,
   output logic             in_data,
   output logic             req_n,
   output logic             frame_n,
   output logic             irdy_n,
   output logic             busy,
   output logic             done,
   output logic             abort_err
);
   localparam int               DCNT_W    = (ABORT_CLKS > 2) ? $clog2(ABORT_CLKS) : 1;
   localparam logic [DCNT_W-1:0] DCNT_LAST = DCNT_W'(ABORT_CLKS - 1);
   localparam logic [CNT_W-1:0]  CNT_ONE   = CNT_W'(1);

   seq_state_t        state_q, state_d;
   logic [CNT_W-1:0]  left_q;
   logic              burst_q;
   logic [DCNT_W-1:0] dcnt_q;
   logic              claimed_q;
   logic              done_q;
   logic              err_q;

   logic final_txn, last_phase, last_word, abort_now;

   assign load       = (state_q == ST_IDLE) && start && (start_cnt != '0);
   assign in_addr    = (state_q == ST_ADDR);
   assign in_data    = (state_q == ST_DATA);
   assign last_word  = (left_q == CNT_ONE);
   assign final_txn  = burst_q || last_word;
   assign last_phase = !burst_q || last_word;
   assign phase_done = in_data && !trdy_n;
   assign abort_now  = in_data && !trdy_n == 1'b0 && !claimed_q && devsel_n
                       && (dcnt_q == DCNT_LAST);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: if (load) state_d = ST_REQ;
         ST_REQ:  if (!gnt_n) state_d = ST_ADDR;
         ST_ADDR: state_d = ST_DATA;
         ST_DATA: begin
            if (abort_now)          state_d = ST_IDLE;
            else if (phase_done) begin
               if (last_word)       state_d = ST_IDLE;
               else if (burst_q)    state_d = ST_DATA;
               else                 state_d = ST_GAP;
            end
         end
         ST_GAP:  state_d = gnt_n ? ST_REQ : ST_ADDR;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         left_q    <= '0;
         burst_q   <= 1'b0;
         dcnt_q    <= '0;
         claimed_q <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         state_q <= state_d;
         done_q  <= phase_done && last_word;
         if (load) begin
            left_q  <= start_cnt;
            burst_q <= cfg_burst;
            err_q   <= 1'b0;
         end else if (phase_done) begin
            left_q  <= left_q - CNT_ONE;
         end
         if (abort_now) err_q <= 1'b1;
         if (in_addr) begin
            dcnt_q    <= '0;
            claimed_q <= 1'b0;
         end else if (in_data && !claimed_q) begin
            if (!devsel_n) claimed_q <= 1'b1;
            else           dcnt_q    <= dcnt_q + DCNT_W'(1);
         end
      end
   end

   assign req_n     = !((state_q == ST_REQ) || (state_q == ST_GAP) ||
                        ((in_addr || in_data) && !final_txn));
   assign frame_n   = !(in_addr || (in_data && !last_phase));
   assign irdy_n    = !in_data;
   assign busy      = (state_q != ST_IDLE);
   assign done      = done_q;
   assign abort_err = err_q;
endmodule

// File: rtl/pciw_addr_dp.sv
module pciw_addr_dp
   import pciw_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [WADDR_W-1:0] start_waddr,
   input  logic               advance,
   input  logic               in_addr,
   input  logic               in_data,
   input  logic [BUS_W-1:0]   word_data,
   input  logic [LANES-1:0]   word_be,
   output logic [BUS_W-1:0]   ad,
   output logic [LANES-1:0]   cbe_n,
   output logic               drive
);
   logic [WADDR_W-1:0] waddr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       waddr_q <= '0;
      else if (load)    waddr_q <= start_waddr;
      else if (advance) waddr_q <= waddr_q + WADDR_W'(1);
   end

   assign drive = in_addr || in_data;

   always_comb begin
      if (in_addr)      ad = {waddr_q, 2'b00};
      else if (in_data) ad = word_data;
      else              ad = '0;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign cbe_n[i] = in_addr ? CMD_MEM_WR[i] :
                        in_data ? ~word_be[i]   : 1'b1;
   end
endmodule

// File: rtl/pciw_par_gen.sv
module pciw_par_gen
   import pciw_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             drive,
   input  logic [BUS_W-1:0] ad,
   input  logic [LANES-1:0] cbe_n,
   output logic             par
);
   logic par_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) par_q <= 1'b0;
      else        par_q <= drive ? ^{ad, cbe_n} : 1'b0;
   end

   assign par = par_q;
endmodule

// File: rtl/pciw_master_write.sv
module pciw_master_write
   import pciw_pkg::*;
#(
   parameter int CNT_W      = 8,
   parameter int ABORT_CLKS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [29:0]      start_waddr,
   input  logic [CNT_W-1:0] start_cnt,
   input  logic             cfg_burst,
   input  logic [31:0]      word_data,
   input  logic [3:0]       word_be,
   output logic             word_take,
   output logic             busy,
   output logic             done,
   output logic             abort_err,
   output logic             req_n,
   input  logic             gnt_n,
   output logic             frame_n,
   output logic             irdy_n,
   input  logic             devsel_n,
   input  logic             trdy_n,
   output logic [31:0]      ad,
   output logic [3:0]       cbe_n,
   output logic             par
);
   if (CNT_W < 1 || CNT_W > 16) begin : g_bad_cnt
      $error("pciw_master_write: CNT_W must lie in 1..16");
   end
   if (ABORT_CLKS < 2 || ABORT_CLKS > 16) begin : g_bad_abort
      $error("pciw_master_write: ABORT_CLKS must lie in 2..16");
   end

   logic load, phase_done, in_addr, in_data, drive;

   pciw_seq #(.CNT_W(CNT_W), .ABORT_CLKS(ABORT_CLKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_cnt(start_cnt),
      .cfg_burst(cfg_burst), .gnt_n(gnt_n), .devsel_n(devsel_n), .trdy_n(trdy_n),
      .load(load), .phase_done(phase_done), .in_addr(in_addr), .in_data(in_data),
      .req_n(req_n), .frame_n(frame_n), .irdy_n(irdy_n), .busy(busy),
      .done(done), .abort_err(abort_err)
   );

   pciw_addr_dp u_dp (
      .clk(clk), .rst_n(rst_n), .load(load), .start_waddr(start_waddr),
      .advance(phase_done), .in_addr(in_addr), .in_data(in_data),
      .word_data(word_data), .word_be(word_be), .ad(ad), .cbe_n(cbe_n),
      .drive(drive)
   );

   pciw_par_gen u_par (
      .clk(clk), .rst_n(rst_n), .drive(drive), .ad(ad), .cbe_n(cbe_n), .par(par)
   );

   assign word_take = phase_done;
endmodule

// File: rtl/pciw_master_write_chk.sv
module pciw_master_write_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        req_n,
   input logic        gnt_n,
   input logic        frame_n,
   input logic        irdy_n,
   input logic        trdy_n,
   input logic [31:0] ad,
   input logic [3:0]  cbe_n,
   input logic        par,
   input logic        busy,
   input logic        done,
   input logic        abort_err
);
   assert_addr_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n && irdy_n) |-> (cbe_n == 4'b0111 && ad[1:0] == 2'b00));

   assert_irdy_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n && irdy_n) |=> !irdy_n);

   assert_last_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!irdy_n && !trdy_n && frame_n) |=> (irdy_n && frame_n));

   assert_req_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_n) |-> ($fell(frame_n) || $rose(abort_err)));

   assert_parity_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n || !irdy_n) |=> (par == $past(^{ad, cbe_n})));

   assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(abort_err) |-> (frame_n && irdy_n && !busy));

   assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && frame_n && irdy_n));

   assert_grant_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(frame_n) |-> $past(!gnt_n));
endmodule

bind pciw_master_write pciw_master_write_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_n(req_n), .gnt_n(gnt_n), .frame_n(frame_n),
   .irdy_n(irdy_n), .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n), .par(par),
   .busy(busy), .done(done), .abort_err(abort_err)
);

// File: tb/sim_pciw_master_write.sv
`timescale 1ns/1ps
module sim_pciw_master_write;
   localparam int CNT_W = 8;

   typedef struct {
      logic [31:0] a;
      logic [31:0] d;
      logic [3:0]  be;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [29:0] start_waddr = '0;
   logic [CNT_W-1:0] start_cnt = '0;
   logic cfg_burst = 1'b0;
   logic [31:0] word_data;
   logic [3:0]  word_be;
   logic word_take, busy, done, abort_err, req_n, frame_n, irdy_n, par;
   logic gnt_n = 1'b1, devsel_n = 1'b1, trdy_n = 1'b1;
   logic [31:0] ad;
   logic [3:0]  cbe_n;

   int tchecks = 0, terrs = 0, mchecks = 0, merrs = 0;
   int opnum = 0, idx = 0, base = 0;
   int dly_dev = 0, dly_trdy = 0, dcyc = 0, addr_seen = 0;
   logic mode_burst = 1'b0, gnt_en = 1'b1;
   logic prev_frame_n = 1'b1, prev_irdy_n = 1'b1, prev_addr = 1'b0;
   logic prev_drive = 1'b0, prev_par = 1'b0, prev_gnt_n = 1'b1;
   item_t sb[$];

   always #10 clk = ~clk;

   function automatic logic [31:0] wdat(int op, int k);
      return 32'hC0DE0000 ^ (32'(op) << 20) ^ (32'(k) * 32'h00010203) ^ 32'(k);
   endfunction
   function automatic logic [3:0] wbe(int k);
      case (k % 4)
         0: return 4'hF;
         1: return 4'h3;
         2: return 4'hC;
         default: return 4'h5;
      endcase
   endfunction

   assign word_data = wdat(opnum, idx - base);
   assign word_be   = wbe(idx - base);

   always @(posedge clk) if (word_take) idx <= idx + 1;

   pciw_master_write #(.CNT_W(CNT_W), .ABORT_CLKS(4)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_waddr(start_waddr),
      .start_cnt(start_cnt), .cfg_burst(cfg_burst), .word_data(word_data),
      .word_be(word_be), .word_take(word_take), .busy(busy), .done(done),
      .abort_err(abort_err), .req_n(req_n), .gnt_n(gnt_n), .frame_n(frame_n),
      .irdy_n(irdy_n), .devsel_n(devsel_n), .trdy_n(trdy_n), .ad(ad),
      .cbe_n(cbe_n), .par(par)
   );

   task automatic mchk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      mchecks++;
      if (act !== exp) begin
         merrs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tchk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tchecks++;
      if (act !== exp) begin
         terrs++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   // Monitor and target/arbiter model: one process per negedge
   always @(negedge clk) begin
      if (!rst_n) begin
         devsel_n = 1'b1; trdy_n = 1'b1; gnt_n = 1'b1; dcyc = 0;
         prev_frame_n = 1'b1; prev_irdy_n = 1'b1; prev_addr = 1'b0;
         prev_drive = 1'b0; prev_gnt_n = 1'b1;
      end else begin
         if (!frame_n && prev_frame_n) begin
            addr_seen++;
            mchk("R2 address command", {28'h0, cbe_n}, 32'h7);
            mchk("R2 address alignment", {30'h0, ad[1:0]}, 32'h0);
            if (sb.size() > 0) mchk("R2 address value", ad, sb[0].a);
            if (mode_burst) mchk("R8 req at burst address", {31'h0, req_n}, 32'h1);
            else mchk("R6 req at address phase", {31'h0, req_n},
                      (sb.size() == 1) ? 32'h1 : 32'h0);
            mchk("R12 grant before address", {31'h0, prev_gnt_n}, 32'h0);
            mchk("R5 idle clock before address", {31'h0, prev_irdy_n}, 32'h1);
         end
         if (prev_addr) mchk("R4 irdy after address", {31'h0, irdy_n}, 32'h0);
         if (prev_drive) mchk("R9 parity", {31'h0, par}, {31'h0, prev_par});

         if (!irdy_n) begin
            devsel_n = (dcyc >= dly_dev) ? 1'b0 : 1'b1;
            trdy_n   = (dcyc >= dly_dev + dly_trdy) ? 1'b0 : 1'b1;
            if (dcyc < 1000) dcyc++;
         end else begin
            devsel_n = 1'b1; trdy_n = 1'b1; dcyc = 0;
         end
         gnt_n = !(gnt_en && !req_n);
         #1;
         if (!irdy_n && !trdy_n) begin
            if (sb.size() == 0) begin
               mchk("R3 unexpected data phase", 32'h1, 32'h0);
            end else begin
               item_t it;
               it = sb.pop_front();
               mchk("R3 data word", ad, it.d);
               mchk("R3 byte enables", {28'h0, cbe_n}, {28'h0, ~it.be});
               mchk("R3 word_take", {31'h0, word_take}, 32'h1);
               if (mode_burst) mchk("R7 frame in burst phase", {31'h0, frame_n},
                                    (sb.size() == 0) ? 32'h1 : 32'h0);
               else mchk("R5 frame high in single phase", {31'h0, frame_n}, 32'h1);
            end
         end
         prev_addr    = !frame_n && irdy_n;
         prev_drive   = !frame_n || !irdy_n;
         prev_par     = ^{ad, cbe_n};
         prev_frame_n = frame_n;
         prev_irdy_n  = irdy_n;
         prev_gnt_n   = gnt_n;
      end
   end

   task automatic run_op(input logic burst, input int n, input logic [31:0] a0,
                         input int dd, input int dt, input logic exp_abort, input string tag);
      int a_start;
      opnum++;
      dly_dev = dd; dly_trdy = dt; mode_burst = burst;
      base = idx;
      for (int k = 0; k < n; k++) begin
         item_t it;
         it.a = a0 + 32'(4 * k); it.d = wdat(opnum, k); it.be = wbe(k);
         sb.push_back(it);
      end
      a_start = addr_seen;
      start = 1'b1; start_waddr = a0[31:2]; start_cnt = CNT_W'(n); cfg_burst = burst;
      @(negedge clk);
      start = 1'b0;
      for (int t = 0; t < 2000; t++) begin
         if (done || abort_err) break;
         @(negedge clk);
      end
      tchk({tag, " busy low at end"}, {31'h0, busy}, 32'h0);
      if (exp_abort) begin
         tchk("R10 abort flag", {31'h0, abort_err}, 32'h1);
         tchk("R10 bus released", {30'h0, frame_n, irdy_n}, 32'h3);
         tchk("R10 no word consumed", 32'(sb.size()), 32'(n));
         sb.delete();
      end else begin
         tchk("R11 done pulse", {31'h0, done}, 32'h1);
         tchk("R3 all words written", 32'(sb.size()), 32'h0);
         if (burst) tchk("R7 one address phase", 32'(addr_seen - a_start), 32'h1);
         else       tchk("R5 one address phase per word", 32'(addr_seen - a_start), 32'(n));
         @(negedge clk);
         tchk("R11 done is one clock", {31'h0, done}, 32'h0);
      end
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            tchk("R1 req_n in reset", {31'h0, req_n}, 32'h1);
            tchk("R1 frame/irdy in reset", {30'h0, frame_n, irdy_n}, 32'h3);
            tchk("R1 busy/abort in reset", {30'h0, busy, abort_err}, 32'h0);
            rst_n = 1'b1;
            @(negedge clk);
            run_op(1'b0, 3, 32'h0000_1000, 0, 0, 1'b0, "R5 single-phase batch");
            run_op(1'b0, 2, 32'h2000_0040, 1, 1, 1'b0, "R4 waits single-phase");
            run_op(1'b1, 4, 32'h0000_3000, 0, 0, 1'b0, "R7 burst zero wait");
            run_op(1'b1, 3, 32'h0000_4010, 2, 1, 1'b0, "R4 burst with waits");
            run_op(1'b1, 1, 32'h0000_5000, 0, 0, 1'b0, "R7 one-word burst");
            run_op(1'b1, 2, 32'h0000_6000, 3, 0, 1'b0, "R10 late claim accepted");
            run_op(1'b0, 2, 32'h0000_7000, 4, 0, 1'b1, "R10 abort single-phase");
            run_op(1'b1, 3, 32'h0000_8000, 99, 0, 1'b1, "R10 abort burst");
            run_op(1'b0, 1, 32'h0000_9000, 0, 2, 1'b0, "R6 single word");
            // R11 zero count is ignored
            start = 1'b1; start_cnt = '0; cfg_burst = 1'b0;
            @(negedge clk);
            start = 1'b0;
            repeat (4) @(negedge clk);
            tchk("R11 zero count ignored busy", {31'h0, busy}, 32'h0);
            tchk("R11 zero count ignored req", {31'h0, req_n}, 32'h1);
            // R12 grant withheld
            gnt_en = 1'b0;
            fork
               run_op(1'b0, 2, 32'h0000_A000, 0, 0, 1'b0, "R12 delayed grant");
               begin
                  repeat (8) @(negedge clk);
                  tchk("R12 no frame without grant", {31'h0, frame_n}, 32'h1);
                  tchk("R12 request held", {31'h0, req_n}, 32'h0);
                  gnt_en = 1'b1;
               end
            join
         end
         begin
            repeat (50000) @(posedge clk);
            terrs++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("Simulation finished: %0d checks, %0d errors", tchecks + mchecks, terrs + merrs);
      $finish;
   end
endmodule